// File: doc/BRIEF.md
# Write Unlock Sequence Detector

This block guards a page-programmed memory against stray writes. It sits behind the write path, which captures an address and data pair for each write strobe. Programming is allowed only after three exact command bytes have arrived in order. The command bytes themselves are never stored. Once the sequence is complete, the page loader may accept between one and a page's worth of data bytes.

A write attempt that does not follow the sequence is not simply dropped. It raises a one-cycle indication that tells the programming timer to run its busy period while storing nothing. When the programming cycle ends, or when the byte-load window lapses partway through the sequence, protection is restored. Every program operation therefore needs a fresh unlock sequence. Reset leaves the block protected.

The key addresses and data values are parameters. Their defaults, in step order, are: data AAh at address 5555h, then data 55h at address 2AAAh, then data A0h at address 5555h.

Top module: `write_unlock`

## Requirements
- R1: After reset, `writeOk`, `storeStb` and `discardStb` are all low.
- R2: The three command bytes, accepted in step order (AAh@5555h, 55h@2AAAh, A0h@5555h), raise `writeOk` one cycle after the third byte. None of the three bytes produces a `storeStb` or `discardStb` pulse.
- R3: While `writeOk` is high, each `byteValid` produces exactly one `storeStb` pulse in the following cycle. This includes bytes whose address or data equals a command value.
- R4: A byte that does not match the expected step produces one `discardStb` pulse in the following cycle. This applies to the first step, which is an unprotected write, as well as to the second and third steps. `writeOk` stays low after such a byte, and later bytes produce no strobe until `progDone`.
- R5: If `windowExpired` is asserted while the sequence is partly entered, the partial sequence is dropped silently. A byte in that same cycle is judged as the first step.
- R6: If `windowExpired` is asserted while `writeOk` is high, `writeOk` falls in the next cycle. Later bytes produce no strobe until `progDone`.
- R7: `progDone` returns the block to the protected state from any state. After that, a write without the sequence produces `discardStb`.
- R8: After PAGE_BYTES stored bytes, `writeOk` falls. Further bytes produce no strobe.
- R9: `storeStb` and `discardStb` are never high together. Each pulse follows a cycle with `byteValid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A captured write byte is present |
| byteAddr | input | ADDR_W (15) | Captured write address |
| byteData | input | DATA_W (8) | Captured write data |
| windowExpired | input | 1 | The byte-load window has lapsed |
| progDone | input | 1 | The programming cycle has finished |
| writeOk | output | 1 | Bytes may be stored by the page loader |
| storeStb | output | 1 | Store the previous cycle's byte |
| discardStb | output | 1 | Start the busy timer and discard the data |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes are mutually exclusive and each follows a captured byte;
- a store happens only while writing is permitted;
- the stored-byte count stays within the page;
- the unlocked state is entered only from the second step on a matching byte;
- window expiry while unlocked leads to the busy state.

Other behaviours can only be shown by the bench's scenarios:
- which bytes are swallowed as commands;
- a mismatch at each step in turn;
- a window expiry coinciding with a restart byte;
- the exact page limit;
- the need for a new sequence after each programming cycle.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  typedef enum logic [2:0] {
    ST_LOCKED,
    ST_STEP1,
    ST_STEP2,
    ST_OPEN,
    ST_BUSY
  } lockState_t;

  typedef struct packed {
    logic storeNow;
    logic discardNow;
    logic clearCount;
    logic openLevel;
  } dpStrobe_t;

endpackage

// File: rtl/unlock_dp.sv
module unlock_dp
  import unlock_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int STEPS      = 3,
  parameter logic [STEPS*ADDR_W-1:0] KEY_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [STEPS*DATA_W-1:0] KEY_DATA = {8'hA0, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteData,
  input  dpStrobe_t         strobe,
  output logic [STEPS-1:0]  stepHit,
  output logic              pageFull,
  output logic              writeOk,
  output logic              storeStb,
  output logic              discardStb
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] storedCount;

  // One comparator per step; step 0 sits in the low slice of each key vector.
  for (genvar s = 0; s < STEPS; s++) begin : g_step
    assign stepHit[s] = (byteAddr == KEY_ADDR[s*ADDR_W +: ADDR_W]) &&
                        (byteData == KEY_DATA[s*DATA_W +: DATA_W]);
  end

  assign pageFull = (storedCount == CNT_MAX);
  assign writeOk  = strobe.openLevel && !pageFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedCount <= '0;
      storeStb    <= 1'b0;
      discardStb  <= 1'b0;
    end else begin
      storeStb   <= strobe.storeNow;
      discardStb <= strobe.discardNow;
      if (strobe.clearCount)
        storedCount <= '0;
      else if (strobe.storeNow)
        storedCount <= storedCount + 1'b1;
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    storedCount <= CNT_MAX);

  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rstN)
    pageFull |=> !storeStb);

endmodule

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             windowExpired,
  input  logic             progDone,
  input  logic [STEPS-1:0] stepHit,
  input  logic             pageFull,
  output dpStrobe_t        strobe
);

  lockState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.openLevel = (state == ST_OPEN);
    if (progDone) begin
      nextState = ST_LOCKED;
    end else begin
      case (state)
        ST_LOCKED: begin
          if (byteValid) begin
            if (stepHit[0]) nextState = ST_STEP1;
            else begin
              nextState         = ST_BUSY;
              strobe.discardNow = 1'b1;
            end
          end
        end
        ST_STEP1, ST_STEP2: begin
          if (windowExpired) begin
            // Partial sequence dropped; a byte now counts as a new first step.
            nextState = ST_LOCKED;
            if (byteValid) begin
              if (stepHit[0]) nextState = ST_STEP1;
              else begin
                nextState         = ST_BUSY;
                strobe.discardNow = 1'b1;
              end
            end
          end else if (byteValid) begin
            if ((state == ST_STEP1) ? stepHit[1] : stepHit[2]) begin
              nextState = (state == ST_STEP1) ? ST_STEP2 : ST_OPEN;
              strobe.clearCount = (state == ST_STEP2);
            end else begin
              nextState         = ST_BUSY;
              strobe.discardNow = 1'b1;
            end
          end
        end
        ST_OPEN: begin
          if (windowExpired) nextState = ST_BUSY;
          else if (byteValid && !pageFull) strobe.storeNow = 1'b1;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= nextState;
  end

  a_r2_open_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_OPEN) |-> $past(state == ST_STEP2 && byteValid && stepHit[2]));

  a_r6_expire_closes: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OPEN && windowExpired && !progDone) |=> (state == ST_BUSY));

  a_r7_done_locks: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> (state == ST_LOCKED));

endmodule

// File: rtl/write_unlock.sv
module write_unlock
  import unlock_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic              windowExpired,
  input  logic              progDone,
  output logic              writeOk,
  output logic              storeStb,
  output logic              discardStb
);

  localparam int STEPS = 3;

  dpStrobe_t        strobe;
  logic [STEPS-1:0] stepHit;
  logic             pageFull;

  unlock_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid),
    .windowExpired(windowExpired), .progDone(progDone),
    .stepHit(stepHit), .pageFull(pageFull), .strobe(strobe)
  );

  unlock_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .STEPS(STEPS),
    .KEY_ADDR({ADDR_W'(15'h5555), ADDR_W'(15'h2AAA), ADDR_W'(15'h5555)}),
    .KEY_DATA({DATA_W'(8'hA0), DATA_W'(8'h55), DATA_W'(8'hAA)})
  ) u_dp (
    .clk(clk), .rstN(rstN), .byteAddr(byteAddr), .byteData(byteData),
    .strobe(strobe), .stepHit(stepHit), .pageFull(pageFull),
    .writeOk(writeOk), .storeStb(storeStb), .discardStb(discardStb)
  );

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(storeStb && discardStb));

  a_r9_store_cause: assert property (@(posedge clk) disable iff (!rstN)
    storeStb |-> $past(byteValid && writeOk));

  a_r9_discard_cause: assert property (@(posedge clk) disable iff (!rstN)
    discardStb |-> $past(byteValid));

  a_r4_discard_closed: assert property (@(posedge clk) disable iff (!rstN)
    discardStb |-> !writeOk);

endmodule

// File: tb/sim_write_unlock.sv
module sim_write_unlock;

  localparam int PAGE = 64;
  localparam int K_NONE = 0, K_STORE = 1, K_DISCARD = 2;

  typedef struct {
    int    kind;
    string req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [14:0] byteAddr = '0;
  logic [7:0]  byteData = '0;
  logic        windowExpired = 1'b0;
  logic        progDone = 1'b0;
  logic        writeOk, storeStb, discardStb;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  logic sampledValid = 1'b0;

  always #4 clk = ~clk;

  write_unlock #(.PAGE_BYTES(PAGE)) u0 (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteAddr(byteAddr),
    .byteData(byteData), .windowExpired(windowExpired), .progDone(progDone),
    .writeOk(writeOk), .storeStb(storeStb), .discardStb(discardStb)
  );

  function automatic int kindOf(logic s, logic d);
    return d ? (s ? 3 : K_DISCARD) : (s ? K_STORE : K_NONE);
  endfunction

  // Monitor: compare each cycle's strobes against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      sampledValid = byteValid;
      @(negedge clk);
      #1;
      if (rstN) begin
        expItem_t e;
        int got;
        got = kindOf(storeStb, discardStb);
        if (sampledValid && expQ.size() > 0) e = expQ.pop_front();
        else begin e.kind = K_NONE; e.req = "R9"; end
        checks++;
        if (got != e.kind) begin
          errors++;
          $display("FAIL %s: strobe kind %0d expected %0d", e.req, got, e.kind);
        end
      end
    end
  end

  task automatic putByte(input logic [14:0] a, input logic [7:0] d,
                         input int kind, input string req, input logic exp = 1'b0);
    expItem_t e;
    @(negedge clk);
    byteValid = 1'b1; byteAddr = a; byteData = d; windowExpired = exp;
    e.kind = kind; e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    byteValid = 1'b0; windowExpired = 1'b0;
  endtask

  task automatic pulseExpire();
    @(negedge clk); windowExpired = 1'b1;
    @(negedge clk); windowExpired = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); progDone = 1'b1;
    @(negedge clk); progDone = 1'b0;
  endtask

  task automatic checkOk(input logic exp, input string req);
    @(negedge clk); #2;
    checks++;
    if (writeOk !== exp) begin
      errors++;
      $display("FAIL %s: writeOk %0b expected %0b", req, writeOk, exp);
    end
  endtask

  task automatic unlockSeq(input string req);
    putByte(15'h5555, 8'hAA, K_NONE, req);
    putByte(15'h2AAA, 8'h55, K_NONE, req);
    putByte(15'h5555, 8'hA0, K_NONE, req);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rstN = 1'b1;
        // R1 reset state
        checkOk(1'b0, "R1");
        checks++;
        if (storeStb || discardStb) begin
          errors++;
          $display("FAIL R1: strobes %0b%0b expected 00", storeStb, discardStb);
        end
        // R2 unlock, R3 stores including command-looking byte
        unlockSeq("R2");
        checkOk(1'b1, "R2");
        putByte(15'h0100, 8'h12, K_STORE, "R3");
        putByte(15'h5555, 8'hAA, K_STORE, "R3");
        // R6 expiry while open
        pulseExpire();
        checkOk(1'b0, "R6");
        putByte(15'h0101, 8'h34, K_NONE, "R6");
        // R7 done re-protects
        pulseDone();
        checkOk(1'b0, "R7");
        putByte(15'h0040, 8'h33, K_DISCARD, "R7");
        checkOk(1'b0, "R4");
        putByte(15'h0041, 8'h44, K_NONE, "R4");
        pulseDone();
        // R4 mismatch at step 2 and step 3
        putByte(15'h5555, 8'hAA, K_NONE, "R4");
        putByte(15'h2AAA, 8'h56, K_DISCARD, "R4");
        pulseDone();
        putByte(15'h5555, 8'hAA, K_NONE, "R4");
        putByte(15'h2AAA, 8'h55, K_NONE, "R4");
        putByte(15'h5554, 8'hA0, K_DISCARD, "R4");
        checkOk(1'b0, "R4");
        pulseDone();
        // R5 expiry mid-sequence drops progress
        putByte(15'h5555, 8'hAA, K_NONE, "R5");
        pulseExpire();
        putByte(15'h2AAA, 8'h55, K_DISCARD, "R5");
        pulseDone();
        // R5 expiry together with a restart byte
        putByte(15'h5555, 8'hAA, K_NONE, "R5");
        putByte(15'h5555, 8'hAA, K_NONE, "R5", 1'b1);
        putByte(15'h2AAA, 8'h55, K_NONE, "R5");
        putByte(15'h5555, 8'hA0, K_NONE, "R5");
        checkOk(1'b1, "R5");
        // R8 page limit
        for (int i = 0; i < PAGE; i++)
          putByte(15'(i), 8'(i + 1), K_STORE, "R8");
        checkOk(1'b0, "R8");
        putByte(15'h0007, 8'h99, K_NONE, "R8");
        pulseDone();
        checkOk(1'b0, "R7");
        repeat (3) @(negedge clk);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule